// File: doc/BRIEF.md
# Continuation-Passing Fibonacci Engine

The engine computes the Fibonacci number of an 8-bit operand. It does not use a hardware call stack. The doubly recursive definition is rewritten in continuation-passing form, and one state machine then runs it by moving between two kinds of step:

- **Evaluate.** Compute fib(n) and pass the answer to continuation k.
- **Apply.** Hand a value to a continuation that has been fetched from memory.

A pending continuation is a tagged record kept in a single-port RAM and addressed by a reference. There are three kinds of record:

- **Terminal.** Ends the computation.
- **After-first-call.** Keeps the original operand and a link to the next record.
- **After-second-call.** Keeps the first partial sum and a link to the next record.

Each RAM word holds a 2-bit tag, a 32-bit value field and a link field sized to the RAM depth. Tag 0 is terminal, tag 1 is after-first-call and tag 2 is after-second-call.

Records are handed out by a bump allocator. A new run resets the allocator to address 0 and writes the terminal record there. Every later record takes the next free address, and no address is ever reclaimed. A run on operand n therefore needs 1 + 2·I(n) words, where I(n) is the number of calls with an operand above 2. With the default depth of 128 words, every operand up to 10 fits (10 needs 109 words) and 11 does not (it needs 177). When a record has to be written and no free word is left, the run is aborted and an error flag is raised.

Software pulses `start` with the operand, then waits for the one-cycle `done` pulse and reads `result` and `error`.

Top module: `cont_fib_engine`

## Requirements
- R1: For an operand of 1 or 2, the run completes with `result` = 1 and `error` = 0.
- R2: For any operand whose run fits in the continuation RAM, `result` equals fib(n) with fib(1) = fib(2) = 1, taken modulo 2^32. This includes every operand from 3 to 10 at the default depth of 128.
- R3: An operand of 0 is treated as 1 and gives `result` = 1.
- R4: `done` is high for exactly one cycle at the end of each run. `result` changes only in a cycle where `done` is high, and holds its value until the next completion.
- R5: A `start` that arrives while a run is in progress is ignored. The current run finishes with its own answer, and no second completion follows.
- R6: When a record must be stored and all DEPTH words are in use, the run aborts. `done` pulses with `error` = 1 and `result` = 0, and the allocator never points past DEPTH.
- R7: A new `start` clears `error` and restarts allocation from address 0, so a run that follows an abort completes correctly.
- R8: After reset, `done` = 0, `error` = 0, `result` = 0, and the engine accepts `start`.
- R9: The evaluate step never sees an operand of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run; sampled only while idle |
| n | input | 8 | Operand, sampled together with `start` |
| result | output | 32 | fib(n), valid while `done` is high and held afterwards |
| done | output | 1 | One-cycle pulse when a run completes or aborts |
| error | output | 1 | Set when the continuation RAM runs out; cleared by the next `start` |

## Verification
The embedded properties check the following on every clock:

- `done` is never high for two cycles in a row.
- `result` never changes except in a cycle where `done` is high.
- The allocator never moves past the RAM depth.
- An abort always comes with a completion pulse.
- The evaluate step never holds a zero operand.

Only the directed scenarios can show the rest:

- The computed values are correct over a range of operands.
- An operand of 0 is mapped to 1.
- A mid-run `start` has no effect.
- Operand 11 exhausts the RAM.
- A later run recovers cleanly after an abort.

// File: rtl/cont_fib_engine.sv
module cont_fib_engine #(
  parameter int N_W   = 8,
  parameter int VAL_W = 32,
  parameter int DEPTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [N_W-1:0]   n,
  output logic [VAL_W-1:0] result,
  output logic             done,
  output logic             error
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int WW = 2 + VAL_W + AW;
  localparam logic [1:0] TAG_K0 = 2'd0, TAG_K1 = 2'd1, TAG_K2 = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_APPLY} state_t;
  state_t state;

  logic [N_W-1:0]   nreg;
  logic [AW-1:0]    kref;
  logic [PW-1:0]    ptr;
  logic [WW-1:0]    cont;
  logic [VAL_W-1:0] acc;

  logic [WW-1:0] mem [DEPTH];
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [WW-1:0] mem_di;
  logic [WW-1:0] mem_do;

  wire [1:0]       c_tag = cont[WW-1 -: 2];
  wire [VAL_W-1:0] c_val = cont[AW +: VAL_W];
  wire [AW-1:0]    c_ref = cont[AW-1:0];
  wire             full  = (ptr == PW'(DEPTH));
  wire             leaf  = (nreg <= N_W'(2));

  assign mem_do = mem[mem_addr];

  always_comb begin
    mem_we   = 1'b0;
    mem_addr = kref;
    mem_di   = '0;
    case (state)
      S_IDLE: begin
        mem_we   = start;
        mem_addr = '0;
        mem_di   = {TAG_K0, {VAL_W{1'b0}}, {AW{1'b0}}};
      end
      S_EVAL: if (!leaf && !full) begin
        mem_we   = 1'b1;
        mem_addr = ptr[AW-1:0];
        mem_di   = {TAG_K1, VAL_W'(nreg), kref};
      end
      S_APPLY: begin
        if (c_tag == TAG_K1 && !full) begin
          mem_we   = 1'b1;
          mem_addr = ptr[AW-1:0];
          mem_di   = {TAG_K2, acc, c_ref};
        end else if (c_tag == TAG_K2) begin
          mem_addr = c_ref;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_di;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      nreg   <= '0;
      kref   <= '0;
      ptr    <= '0;
      cont   <= '0;
      acc    <= '0;
      result <= '0;
      done   <= 1'b0;
      error  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          ptr   <= PW'(1);
          kref  <= '0;
          nreg  <= (n == '0) ? N_W'(1) : n;
          error <= 1'b0;
          state <= S_EVAL;
        end
        S_EVAL: begin
          if (leaf) begin
            cont  <= mem_do;
            acc   <= VAL_W'(1);
            state <= S_APPLY;
          end else if (full) begin
            error <= 1'b1; done <= 1'b1; result <= '0; state <= S_IDLE;
          end else begin
            kref <= ptr[AW-1:0];
            ptr  <= ptr + PW'(1);
            nreg <= nreg - N_W'(1);
          end
        end
        S_APPLY: begin
          case (c_tag)
            TAG_K0: begin
              result <= acc; done <= 1'b1; state <= S_IDLE;
            end
            TAG_K1: if (full) begin
              error <= 1'b1; done <= 1'b1; result <= '0; state <= S_IDLE;
            end else begin
              kref  <= ptr[AW-1:0];
              ptr   <= ptr + PW'(1);
              nreg  <= c_val[N_W-1:0] - N_W'(2);
              state <= S_EVAL;
            end
            TAG_K2: begin
              cont <= mem_do;
              acc  <= c_val + acc;
            end
            default: begin
              error <= 1'b1; done <= 1'b1; result <= '0; state <= S_IDLE;
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_result_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(DEPTH));
  assert_abort_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(error) |-> done);
  assert_eval_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_EVAL) |-> (nreg != '0));
endmodule

// File: tb/sim_cont_fib_engine.sv
module sim_cont_fib_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  n = '0;
  logic [31:0] result;
  logic        done;
  logic        error;

  int checks = 0;
  int fails  = 0;
  int got_cycles;

  cont_fib_engine u0 (.clk(clk), .rst_n(rst_n), .start(start), .n(n),
                      .result(result), .done(done), .error(error));

  always #4 clk = ~clk;

  function automatic logic [31:0] fib_ref(input int v);
    logic [31:0] a = 1, b = 1, t;
    if (v <= 2) return 32'd1;
    for (int i = 3; i <= v; i++) begin
      t = a + b; a = b; b = t;
    end
    return b;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_done();
    got_cycles = 0;
    while (!done && got_cycles < 5000) begin
      @(negedge clk);
      got_cycles++;
    end
    check(done, "timeout", got_cycles, 0);
  endtask

  task automatic launch(input logic [7:0] v);
    @(negedge clk);
    n = v; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_and_check(input logic [7:0] v, input logic [31:0] exp, input string req);
    launch(v);
    wait_done();
    check(result == exp, req, result, exp);
    check(error == 1'b0, req, error, 0);
    @(negedge clk);
    check(done == 1'b0, "R4 pulse", done, 0);
  endtask

  task automatic t_reset();
    check(done == 1'b0,  "R8 done",   done, 0);
    check(error == 1'b0, "R8 error",  error, 0);
    check(result == 0,   "R8 result", result, 0);
  endtask

  task automatic t_small();
    run_and_check(8'd1, 32'd1, "R1 n=1");
    run_and_check(8'd2, 32'd1, "R1 n=2");
  endtask

  task automatic t_general();
    for (int v = 3; v <= 10; v++) run_and_check(8'(v), fib_ref(v), "R2");
  endtask

  task automatic t_zero();
    run_and_check(8'd0, 32'd1, "R3 n=0");
  endtask

  task automatic t_hold();
    logic [31:0] r;
    run_and_check(8'd6, 32'd8, "R4 run");
    r = result;
    repeat (20) @(negedge clk);
    check(result == r, "R4 hold", result, r);
  endtask

  task automatic t_busy();
    bit extra = 0;
    launch(8'd8);
    repeat (3) @(negedge clk);
    n = 8'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();
    check(result == 32'd21, "R5 busy start", result, 21);
    @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      if (done) extra = 1;
      @(negedge clk);
    end
    check(!extra, "R5 no second run", extra, 0);
  endtask

  task automatic t_overflow();
    launch(8'd11);
    wait_done();
    check(error == 1'b1, "R6 error", error, 1);
    check(result == 0,   "R6 result", result, 0);
    @(negedge clk);
    check(done == 1'b0, "R6 pulse", done, 0);
  endtask

  task automatic t_recover();
    launch(8'd7);
    check(error == 1'b0, "R7 error cleared", error, 0);
    wait_done();
    check(result == 32'd13, "R7 result", result, 13);
    check(error == 1'b0, "R7 error", error, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small();
    t_general();
    t_zero();
    t_hold();
    t_busy();
    t_overflow();
    t_recover();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(8 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule